// File: doc/BRIEF.md
# Speculative Load Alias Table

This block lets a compiler hoist a load above a store that may write the same memory. When the early load issues, it records its destination register, its byte address and its access width in a small associative table. Every store that follows presents its byte range. Any recorded load whose bytes overlap that range loses its entry. When the program later reaches the point where the load originally sat, a check operation looks up the destination register. A hit means the early value is still good. A miss tells the pipeline to issue the load again.

The table holds `DEPTH` entries. If the same register is loaded early again, its existing entry is reused. When no entry is free, the entry written least recently is evicted. Its register then misses at check time, which is always safe.

Several operations can arrive in the same cycle, and they resolve in a fixed order:
- The check lookup sees the table as it stood at the start of the cycle.
- A recording from this cycle is written next.
- The store snoop then applies to the table including that new entry.
- An optional clear-on-hit from the check is applied last.

Access width is encoded as a 2-bit value `s` meaning 2^s bytes: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. An entry or a store covers the bytes from its address to address + 2^s − 1.

Top module: `spec_load_table`

## Requirements
- R1: A synchronous reset invalidates every entry, so a later check of any register misses. During the cycle after reset, `rsp_valid` and `rsp_hit` are 0.
- R2: The response is registered. `rsp_valid` is high exactly in the cycle after a cycle with `chk_valid` high. `rsp_hit` is 0 whenever `rsp_valid` is 0.
- R3: After a recording of register r (`ins_valid`), a later check of r hits, provided no overlapping store, clear or eviction came in between.
- R4: A store whose byte range overlaps an entry's byte range invalidates that entry. A store whose range only touches the entry's range, or lies apart from it, has no effect.
- R5: Recording register r while r already has an entry overwrites that entry, so a register never has more than one entry. A store to the old address then has no effect.
- R6: When all entries are valid, a recording of a new register evicts the entry whose last recording is oldest. The evicted register misses at its next check, and all other entries still hit.
- R7: When a recording and an overlapping store happen in the same cycle, the recording is applied first, so the new entry is invalidated.
- R8: A check that hits with `chk_clear` = 1 removes its entry, so the next check of the same register misses.
- R9: A check sees the table as it stood before any recording or store in the same cycle.
- R10: A check of a register that was never recorded misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Record an early load this cycle |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| ins_size | input | 2 | Width code of the early load (2^s bytes) |
| snp_valid | input | 1 | A store is presented this cycle |
| snp_addr | input | ADDR_W | Byte address of the store |
| snp_size | input | 2 | Width code of the store (2^s bytes) |
| chk_valid | input | 1 | Check operation this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | Remove the entry if the check hits |
| rsp_valid | output | 1 | Check response is present (one cycle after `chk_valid`) |
| rsp_hit | output | 1 | 1: the early value is valid; 0: the load must be issued again |

## Verification
A vector table exercises store snoops against one recorded load in several positions:
- a range that ends exactly one byte before the entry;
- a range that starts exactly one byte after the entry;
- a range that overlaps only the entry's last byte or first byte.

These cases separate a correct inclusive range compare from off-by-one or exact-address compares.

Further patterns target the ordering rules:
- a recording and an aliasing store in the same cycle;
- a check in the same cycle as a snoop or a recording;
- a re-recording followed by a store to the stale address.

Directed sequences cover reset clearing and eviction. One eviction case fills the table. Another re-records one register before a further fill, which shows that age follows the most recent recording and not the original allocation order.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int SIZE_W = 2;
  typedef logic [SIZE_W-1:0] size_t;
endpackage

// File: rtl/lat_overlap.sv
module lat_overlap #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]      a_addr,
  input  lat_pkg::size_t         a_size,
  input  logic [ADDR_W-1:0]      b_addr,
  input  lat_pkg::size_t         b_size,
  output logic                   hit
);
  localparam int EXT_W = ADDR_W + 1;
  logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = {1'b0, a_addr};
    b_lo = {1'b0, b_addr};
    a_hi = a_lo + (EXT_W'(1) << a_size) - EXT_W'(1);
    b_hi = b_lo + (EXT_W'(1) << b_size) - EXT_W'(1);
    hit  = (a_lo <= b_hi) && (b_lo <= a_hi);
  end
endmodule

// File: rtl/lat_age.sv
module lat_age #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  // older_q[i][j] = 1 : entry i was last written before entry j
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else if (touch_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (touch_idx == IDX_W'(i)) older_q[i] <= '0;
        else older_q[i][touch_idx] <= 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cand[i] = &(older_q[i] | (DEPTH'(1) << i));
      if (cand[i]) oldest_idx = IDX_W'(i);
    end
  end

  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cand));
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ins_valid,
  input  logic [REG_W-1:0]           ins_reg,
  input  logic [ADDR_W-1:0]          ins_addr,
  input  logic [lat_pkg::SIZE_W-1:0] ins_size,
  input  logic                       snp_valid,
  input  logic [ADDR_W-1:0]          snp_addr,
  input  logic [lat_pkg::SIZE_W-1:0] snp_size,
  input  logic                       chk_valid,
  input  logic [REG_W-1:0]           chk_reg,
  input  logic                       chk_clear,
  output logic                       rsp_valid,
  output logic                       rsp_hit
);
  import lat_pkg::*;

  logic [DEPTH-1:0]  valid_q, valid_nx;
  logic [REG_W-1:0]  reg_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  size_t             size_q [DEPTH];

  logic [DEPTH-1:0]  chk_hit, ins_here, ovl;
  logic [ADDR_W-1:0] nx_addr [DEPTH];
  size_t             nx_size [DEPTH];

  logic              reuse_any, free_any;
  logic [IDX_W-1:0]  reuse_idx, free_idx, oldest_idx, ins_slot;

  // slot choice: same register, else lowest free, else oldest
  always_comb begin
    reuse_any = 1'b0; reuse_idx = '0;
    free_any  = 1'b0; free_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (valid_q[i] && reg_q[i] == ins_reg) begin
        reuse_any = 1'b1; reuse_idx = IDX_W'(i);
      end
      if (!valid_q[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
    end
    ins_slot = reuse_any ? reuse_idx : (free_any ? free_idx : oldest_idx);
  end

  lat_age #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst(rst), .touch_valid(ins_valid),
    .touch_idx(ins_slot), .oldest_idx(oldest_idx)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ins_here[g] = ins_valid && (ins_slot == IDX_W'(g));
    assign chk_hit[g]  = valid_q[g] && (reg_q[g] == chk_reg);
    assign nx_addr[g]  = ins_here[g] ? ins_addr : addr_q[g];
    assign nx_size[g]  = ins_here[g] ? ins_size : size_q[g];

    // snoop sees the table after this cycle's insert
    lat_overlap #(.ADDR_W(ADDR_W)) u_ovl (
      .a_addr(nx_addr[g]), .a_size(nx_size[g]),
      .b_addr(snp_addr),   .b_size(snp_size),
      .hit(ovl[g])
    );

    assign valid_nx[g] = (valid_q[g] | ins_here[g])
                       & ~(snp_valid & ovl[g])
                       & ~(chk_valid & chk_clear & chk_hit[g] & ~ins_here[g]);

    assert_snoop_kills_R4: assert property (@(posedge clk) disable iff (rst)
      snp_valid && ovl[g] |=> !valid_q[g]);
    assert_clear_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
      chk_valid && chk_clear && chk_hit[g] && !ins_here[g] |=> !valid_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_nx;
  end

  // payload: single write port, no reset
  always_ff @(posedge clk) begin
    if (ins_valid) begin
      reg_q[ins_slot]  <= ins_reg;
      addr_q[ins_slot] <= ins_addr;
      size_q[ins_slot] <= ins_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_hit   <= chk_valid && (|chk_hit);
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0) && !rsp_valid && !rsp_hit);
  assert_rsp_follows_chk_R2: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !rsp_valid && !rsp_hit);
  assert_insert_lands_R3: assert property (@(posedge clk) disable iff (rst)
    ins_valid && !snp_valid |=>
      valid_q[$past(ins_slot)] && (reg_q[$past(ins_slot)] == $past(ins_reg)));
  assert_one_entry_per_reg_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_hit));
endmodule

// File: tb/spec_load_table_bench.sv
module spec_load_table_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0, snp_valid = 1'b0, chk_valid = 1'b0, chk_clear = 1'b0;
  logic [6:0]  ins_reg = '0, chk_reg = '0;
  logic [15:0] ins_addr = '0, snp_addr = '0;
  logic [1:0]  ins_size = '0, snp_size = '0;
  logic        rsp_valid, rsp_hit;
  int          n_checks = 0, n_fail = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_table u_spec_load_table (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr), .ins_size(ins_size),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_size(snp_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit)
  );

  typedef struct packed {
    logic iv; logic [6:0] ir; logic [15:0] ia; logic [1:0] is;
    logic sv; logic [15:0] sa; logic [1:0] ss;
    logic cv; logic [6:0] cr; logic cc;
    logic ev; logic eh; logic [3:0] rq;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R3 record r5 at 0x100, 8 bytes
    '{1'b1,7'd5,16'h0100,2'd3, 1'b0,16'h0000,2'd0, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd2},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0, 1'b1,1'b1,4'd3},
    // R9 check beside a non-overlapping snoop
    '{1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h0108,2'd0, 1'b1,7'd5,1'b0, 1'b1,1'b1,4'd9},
    // R4 byte just past the end had no effect
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0, 1'b1,1'b1,4'd4},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h0107,2'd0, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd2},
    // R4 last byte overlapped
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd5,1'b0, 1'b1,1'b0,4'd4},
    // record r6 0x200..0x203, store 0x1FE..0x1FF touches only
    '{1'b1,7'd6,16'h0200,2'd2, 1'b1,16'h01FE,2'd1, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd4},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h01FF,2'd2, 1'b1,7'd6,1'b0, 1'b1,1'b1,4'd4},
    // R4 first byte overlapped
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd6,1'b0, 1'b1,1'b0,4'd4},
    // R7 same-cycle record and aliasing store
    '{1'b1,7'd7,16'h0300,2'd0, 1'b1,16'h0300,2'd3, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd7},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd7,1'b0, 1'b1,1'b0,4'd7},
    // R5 re-record r8, store to stale address
    '{1'b1,7'd8,16'h0400,2'd1, 1'b0,16'h0000,2'd0, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd3},
    '{1'b1,7'd8,16'h0500,2'd1, 1'b0,16'h0000,2'd0, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd5},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b1,16'h0400,2'd1, 1'b0,7'd0,1'b0, 1'b0,1'b0,4'd5},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd8,1'b0, 1'b1,1'b1,4'd5},
    // R8 clear on hit
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd8,1'b1, 1'b1,1'b1,4'd8},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd8,1'b0, 1'b1,1'b0,4'd8},
    // R10 never recorded
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd9,1'b0, 1'b1,1'b0,4'd10},
    // R9 check in the same cycle as its own recording
    '{1'b1,7'd11,16'h0600,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd11,1'b0, 1'b1,1'b0,4'd9},
    '{1'b0,7'd0,16'h0000,2'd0, 1'b0,16'h0000,2'd0, 1'b1,7'd11,1'b0, 1'b1,1'b1,4'd3}
  };

  task automatic check(input logic ok, input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: {rsp_valid,rsp_hit} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 1'b0; snp_valid = 1'b0; chk_valid = 1'b0; chk_clear = 1'b0;
  endtask

  // apply one cycle, sample the registered response after the edge
  task automatic cyc(input logic iv, input logic [6:0] ir, input logic [15:0] ia, input logic [1:0] is,
                     input logic cv, input logic [6:0] cr);
    ins_valid = iv; ins_reg = ir; ins_addr = ia; ins_size = is;
    snp_valid = 1'b0; chk_valid = cv; chk_reg = cr; chk_clear = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_chk(input logic [6:0] r, input logic hit, input string req);
    cyc(1'b0, 7'd0, 16'h0, 2'd0, 1'b1, r);
    check(rsp_valid === 1'b1 && rsp_hit === hit, req, {rsp_valid, rsp_hit}, {1'b1, hit});
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1", {rsp_valid, rsp_hit}, 2'b00);
    expect_chk(7'd5, 1'b0, "R1");

    for (int k = 0; k < NV; k++) begin
      ins_valid = VECS[k].iv; ins_reg = VECS[k].ir; ins_addr = VECS[k].ia; ins_size = VECS[k].is;
      snp_valid = VECS[k].sv; snp_addr = VECS[k].sa; snp_size = VECS[k].ss;
      chk_valid = VECS[k].cv; chk_reg = VECS[k].cr; chk_clear = VECS[k].cc;
      @(posedge clk); #1;
      check(rsp_valid === VECS[k].ev && rsp_hit === VECS[k].eh,
            $sformatf("R%0d vec %0d", VECS[k].rq, k), {rsp_valid, rsp_hit}, {VECS[k].ev, VECS[k].eh});
    end
    idle();

    // R2 no check -> no response
    @(posedge clk); #1;
    check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R2", {rsp_valid, rsp_hit}, 2'b00);

    // R1 reset mid-run wipes recorded entries
    cyc(1'b1, 7'd3, 16'h0700, 2'd0, 1'b0, 7'd0);
    idle(); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1", {rsp_valid, rsp_hit}, 2'b00);
    expect_chk(7'd3, 1'b0, "R1");
    expect_chk(7'd11, 1'b0, "R1");

    // R6 eviction of oldest when full
    for (int k = 0; k < 8; k++) cyc(1'b1, 7'(20 + k), 16'(16'h1000 + 16 * k), 2'd0, 1'b0, 7'd0);
    cyc(1'b1, 7'd28, 16'h2000, 2'd0, 1'b0, 7'd0);
    idle();
    expect_chk(7'd20, 1'b0, "R6");
    expect_chk(7'd21, 1'b1, "R6");
    expect_chk(7'd28, 1'b1, "R6");
    // R6 re-recording makes r21 newest, so r22 is the next victim
    cyc(1'b1, 7'd21, 16'h3000, 2'd0, 1'b0, 7'd0);
    cyc(1'b1, 7'd29, 16'h3100, 2'd0, 1'b0, 7'd0);
    idle();
    expect_chk(7'd22, 1'b0, "R6");
    expect_chk(7'd21, 1'b1, "R6");
    expect_chk(7'd29, 1'b1, "R6");
    expect_chk(7'd27, 1'b1, "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule